// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Persistent Word Pointer

This block is the bus-facing half of a small serial EEPROM on a two-wire (I2C-style) bus. It watches an oversampled SCL/SDA pair for start and stop conditions. It decodes the device-select byte and acknowledges when that byte addresses it. It then either stores bytes into an internal register array or returns bytes from it. SDA is driven only by pulling low, through an open-drain enable.

The block keeps a word pointer that survives from one transaction to the next. A master can therefore issue a select byte with the read bit set and get data without first sending an address. The pointer moves differently by direction. A byte read advances it over the whole array and wraps from the top address to zero. A byte write advances only its low in-page bits, so a long write wraps inside its page.

The density parameter (2, 4, 8 or 16 Kbit) sizes the array. In the larger densities the low chip-select positions of the select byte stop being compared and carry the upper address bits instead.

Top module: `serial_eeprom_slave`

## Requirements
- R1: A select byte whose top nibble is 1010 and whose bits 3..1 equal the strap input `chipSel[2:0]` is acknowledged by pulling SDA low during the 9th SCL pulse. Bit 0 = 1 means read. Any other select byte gets no acknowledge, and the slave leaves SDA released until the next start.
- R2: At 4, 8 and 16 Kbit, the lowest 1, 2 or 3 chip-select positions (bit 1 upward) are not compared. On every acknowledged select, their values replace the pointer bits above bit 7.
- R3: In a write, the byte after the select byte loads pointer bits 7..0. Each following data byte is stored at the pointer and acknowledged.
- R4: After each stored byte, only the pointer's low 3 bits (2 Kbit) or low 4 bits (larger densities) count up, wrapping to zero. All higher pointer bits keep their value.
- R5: Read data leaves MSB first, with each bit placed on SDA while SCL is low. After the 8th bit, the pointer advances by one across the whole array, wrapping from the top address to 0.
- R6: If the master acknowledges a read byte, the next byte comes from the advanced pointer. If it does not, the slave releases SDA and ignores SCL until a start or stop.
- R7: The pointer keeps the position left by the last read or write across stop and start. A read select with no address phase returns the byte at that position.
- R8: A start or stop seen in any state returns the bit/byte sequencer to its idle or select-receive state and releases SDA. The pointer is not changed.
- R9: The slave begins or ends driving SDA only in cycles that follow SCL being sampled low.
- R10: After reset, SDA is released, and SCL pulses without a preceding start cause no drive on SDA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Synchronized SCL level |
| sdaIn | input | 1 | Synchronized SDA level (wired bus value) |
| chipSel | input | 3 | Strapped chip-select value, bit i compared with select bit i+1 |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The storing of a written byte and the in-page advance of the pointer take place on the same clock edge. The store must use the old pointer while the pointer moves to its wrapped value. The bench provokes this by writing two bytes in one transaction starting at the last byte of a page, at both 2 and 16 Kbit. It judges the result by random reads of the page's last byte, which must hold the first byte, and of the page's first byte, which must hold the second. A second overlap, a start arriving while a byte is half received, is provoked mid-address and judged by a current read that must still follow the earlier pointer.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SELECT, ST_ACK_SEL, ST_WADDR, ST_ACK_ADDR,
    ST_WDATA, ST_ACK_DATA, ST_RDATA, ST_RACK, ST_PARK
  } busState_t;

  // strobes from the bus sequencer to the storage/pointer datapath
  typedef struct packed {
    logic rxShift;      // shift sampled SDA into receive register
    logic selCapture;   // copy page field of select byte into pointer
    logic addrLoad;     // load low pointer byte from receive register
    logic byteWrite;    // store received byte, advance pointer in page
    logic readAdvance;  // advance pointer over whole array
    logic txLoad;       // load array byte and drive its MSB
    logic txShift;      // drive next bit of the outgoing byte
    logic ackDrive;     // pull SDA low for an acknowledge
    logic sdaRelease;   // stop pulling SDA
  } strobes_t;

  function automatic int addrBits(input int densityKbit);
    return $clog2(densityKbit * 128);
  endfunction

  function automatic int pageBits(input int densityKbit);
    return $clog2(densityKbit * 128) - 8;
  endfunction

  function automatic int wrapBits(input int densityKbit);
    return (densityKbit == 2) ? 3 : 4;
  endfunction

endpackage

// File: rtl/eeprom_bus_ctrl.sv
module eeprom_bus_ctrl
  import eeprom_pkg::*;
#(
  parameter int DENSITY_KBIT = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] chipSel,
  input  logic [7:0] rxByte,
  output strobes_t   strb
);

  localparam int PAGE_BITS = pageBits(DENSITY_KBIT);

  busState_t  stateQ, stateD;
  logic [3:0] cntQ, cntD;
  logic       isReadQ, isReadD;
  logic       mAckQ, mAckD;
  logic       sclPrevQ, sdaPrevQ;

  logic sclRise, sclFall, startSeen, stopSeen;
  logic [2:0] csOk;
  logic selMatch;

  assign sclRise   = sclIn & ~sclPrevQ;
  assign sclFall   = ~sclIn & sclPrevQ;
  assign startSeen = sclIn & sclPrevQ & sdaPrevQ & ~sdaIn;
  assign stopSeen  = sclIn & sclPrevQ & ~sdaPrevQ & sdaIn;

  always_comb begin
    for (int g = 0; g < 3; g++) begin
      csOk[g] = (g < PAGE_BITS) ? 1'b1 : (rxByte[g+1] == chipSel[g]);
    end
  end

  assign selMatch = (rxByte[7:4] == 4'b1010) && (&csOk);

  always_comb begin
    stateD  = stateQ;
    cntD    = cntQ;
    isReadD = isReadQ;
    mAckD   = mAckQ;
    strb    = '0;
    if (startSeen) begin
      stateD = ST_SELECT;
      cntD   = '0;
      strb.sdaRelease = 1'b1;
    end else if (stopSeen) begin
      stateD = ST_IDLE;
      cntD   = '0;
      strb.sdaRelease = 1'b1;
    end else begin
      case (stateQ)
        ST_SELECT, ST_WADDR, ST_WDATA: begin
          if (sclRise) begin
            strb.rxShift = 1'b1;
            cntD = cntQ + 4'd1;
          end else if (sclFall && cntQ == 4'd8) begin
            cntD = '0;
            if (stateQ == ST_SELECT) begin
              if (selMatch) begin
                strb.ackDrive   = 1'b1;
                strb.selCapture = 1'b1;
                isReadD = rxByte[0];
                stateD  = ST_ACK_SEL;
              end else begin
                stateD = ST_PARK;
              end
            end else if (stateQ == ST_WADDR) begin
              strb.addrLoad = 1'b1;
              strb.ackDrive = 1'b1;
              stateD = ST_ACK_ADDR;
            end else begin
              strb.byteWrite = 1'b1;
              strb.ackDrive  = 1'b1;
              stateD = ST_ACK_DATA;
            end
          end
        end
        ST_ACK_SEL: begin
          if (sclFall) begin
            cntD = '0;
            if (isReadQ) begin
              strb.txLoad = 1'b1;
              stateD = ST_RDATA;
            end else begin
              strb.sdaRelease = 1'b1;
              stateD = ST_WADDR;
            end
          end
        end
        ST_ACK_ADDR, ST_ACK_DATA: begin
          if (sclFall) begin
            cntD = '0;
            strb.sdaRelease = 1'b1;
            stateD = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (sclRise) begin
            cntD = cntQ + 4'd1;
          end else if (sclFall) begin
            if (cntQ == 4'd8) begin
              cntD = '0;
              strb.sdaRelease  = 1'b1;
              strb.readAdvance = 1'b1;
              stateD = ST_RACK;
            end else begin
              strb.txShift = 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (sclRise) begin
            mAckD = ~sdaIn;
          end else if (sclFall) begin
            cntD = '0;
            if (mAckQ) begin
              strb.txLoad = 1'b1;
              stateD = ST_RDATA;
            end else begin
              stateD = ST_PARK;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      cntQ     <= '0;
      isReadQ  <= 1'b0;
      mAckQ    <= 1'b0;
      sclPrevQ <= 1'b1;
      sdaPrevQ <= 1'b1;
    end else begin
      stateQ   <= stateD;
      cntQ     <= cntD;
      isReadQ  <= isReadD;
      mAckQ    <= mAckD;
      sclPrevQ <= sclIn;
      sdaPrevQ <= sdaIn;
    end
  end

endmodule

// File: rtl/eeprom_store.sv
module eeprom_store
  import eeprom_pkg::*;
#(
  parameter int DENSITY_KBIT = 2
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 sdaIn,
  input  strobes_t                             strb,
  output logic [7:0]                           rxByte,
  output logic [addrBits(DENSITY_KBIT)-1:0]    ptr,
  output logic                                 sdaOe
);

  localparam int ADDR_W    = addrBits(DENSITY_KBIT);
  localparam int PAGE_BITS = pageBits(DENSITY_KBIT);
  localparam int WRAP_BITS = wrapBits(DENSITY_KBIT);
  localparam int MEM_BYTES = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'(((1 << PAGE_BITS) - 1) << 8);
  localparam logic [ADDR_W-1:0] LOW_MASK  = ADDR_W'((1 << WRAP_BITS) - 1);
  localparam logic [ADDR_W-1:0] BYTE_MASK = ADDR_W'(8'hFF);

  logic [7:0]        mem [MEM_BYTES];
  logic [7:0]        memRd;
  logic [7:0]        rxReg, txReg;
  logic [ADDR_W-1:0] ptrQ, ptrD, ptrPlus;
  logic              sdaOeQ;

  assign ptrPlus = ptrQ + 1'b1;

  always_comb begin
    ptrD = ptrQ;
    if (strb.selCapture)
      ptrD = (ptrQ & ~PAGE_MASK) | ((ADDR_W'(rxReg[3:1]) << 8) & PAGE_MASK);
    else if (strb.addrLoad)
      ptrD = (ptrQ & ~BYTE_MASK) | ADDR_W'(rxReg);
    else if (strb.byteWrite)
      ptrD = (ptrQ & ~LOW_MASK) | (ptrPlus & LOW_MASK);
    else if (strb.readAdvance)
      ptrD = ptrPlus;
  end

  always_ff @(posedge clk) begin
    if (strb.byteWrite) mem[ptrQ] <= rxReg;
    memRd <= mem[ptrQ];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ   <= '0;
      rxReg  <= '0;
      txReg  <= '0;
      sdaOeQ <= 1'b0;
    end else begin
      ptrQ <= ptrD;
      if (strb.rxShift) rxReg <= {rxReg[6:0], sdaIn};
      if (strb.txLoad) begin
        txReg  <= memRd;
        sdaOeQ <= ~memRd[7];
      end else if (strb.txShift) begin
        txReg  <= {txReg[6:0], 1'b0};
        sdaOeQ <= ~txReg[6];
      end else if (strb.ackDrive) begin
        sdaOeQ <= 1'b1;
      end else if (strb.sdaRelease) begin
        sdaOeQ <= 1'b0;
      end
    end
  end

  assign rxByte = rxReg;
  assign ptr    = ptrQ;
  assign sdaOe  = sdaOeQ;

endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import eeprom_pkg::*;
#(
  parameter int DENSITY_KBIT = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] chipSel,
  output logic       sdaOe
);

  localparam int ADDR_W = addrBits(DENSITY_KBIT);

  strobes_t          strb;
  logic [7:0]        rxByte;
  logic [ADDR_W-1:0] ptrQ;

  eeprom_bus_ctrl #(.DENSITY_KBIT(DENSITY_KBIT)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .chipSel (chipSel),
    .rxByte  (rxByte),
    .strb    (strb)
  );

  eeprom_store #(.DENSITY_KBIT(DENSITY_KBIT)) u_store (
    .clk    (clk),
    .rstN   (rstN),
    .sdaIn  (sdaIn),
    .strb   (strb),
    .rxByte (rxByte),
    .ptr    (ptrQ),
    .sdaOe  (sdaOe)
  );

endmodule

// File: rtl/eeprom_slave_checker.sv
module eeprom_slave_checker
  import eeprom_pkg::*;
#(
  parameter int DENSITY_KBIT = 2
) (
  input logic                              clk,
  input logic                              rstN,
  input logic                              sclIn,
  input logic                              sdaIn,
  input logic                              sdaOe,
  input strobes_t                          strb,
  input logic [addrBits(DENSITY_KBIT)-1:0] ptr
);

  localparam int ADDR_W    = addrBits(DENSITY_KBIT);
  localparam int WRAP_BITS = wrapBits(DENSITY_KBIT);

  // R9: drive changes only after SCL was seen low
  a_r9_drive_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !$past(sclIn));

  // R8: a stop on the bus releases SDA
  a_r8_stop_releases: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn) && !$past(sdaIn) && sdaIn) |=> !sdaOe);

  // R5: read advance covers the whole array
  a_r5_read_full_advance: assert property (@(posedge clk) disable iff (!rstN)
    strb.readAdvance |=> ptr == ADDR_W'($past(ptr) + 1'b1));

  // R4: write advance leaves upper pointer bits alone
  a_r4_write_upper_hold: assert property (@(posedge clk) disable iff (!rstN)
    strb.byteWrite |=> ptr[ADDR_W-1:WRAP_BITS] == $past(ptr[ADDR_W-1:WRAP_BITS]));

  // R4: low in-page bits count by one
  a_r4_write_low_count: assert property (@(posedge clk) disable iff (!rstN)
    strb.byteWrite |=> ptr[WRAP_BITS-1:0] == WRAP_BITS'($past(ptr[WRAP_BITS-1:0]) + 1'b1));

  // R1: at most one drive action per cycle
  a_r1_single_drive_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.txLoad, strb.txShift, strb.ackDrive, strb.sdaRelease}));

endmodule

bind serial_eeprom_slave eeprom_slave_checker #(.DENSITY_KBIT(DENSITY_KBIT)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .sclIn (sclIn),
  .sdaIn (sdaIn),
  .sdaOe (sdaOe),
  .strb  (strb),
  .ptr   (ptrQ)
);

// File: tb/serial_eeprom_slave_tb.sv
module serial_eeprom_slave_tb;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1, busSel = 1'b0;
  logic oeA, oeB, sdaLine, sclA, sclB;
  int   nChecks = 0, nFail = 0;
  bit   done = 0;

  assign sdaLine = sdaM & ~oeA & ~oeB;
  assign sclA    = busSel ? 1'b1 : sclM;
  assign sclB    = busSel ? sclM : 1'b1;

  serial_eeprom_slave #(.DENSITY_KBIT(2)) u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclA), .sdaIn(sdaLine),
    .chipSel(3'b101), .sdaOe(oeA));

  serial_eeprom_slave #(.DENSITY_KBIT(16)) u_dut16 (
    .clk(clk), .rstN(rstN), .sclIn(sclB), .sdaIn(sdaLine),
    .chipSel(3'b000), .sdaOe(oeB));

  typedef struct packed {
    logic [1:0] kind;
    logic [7:0] addr;
    logic [7:0] data;
  } vec_t;
  localparam logic [1:0] KW = 2'd0, KR = 2'd1, KC = 2'd2;
  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{KW, 8'h10, 8'hA5}, '{KW, 8'h11, 8'h3C}, '{KW, 8'h12, 8'h7E},
    '{KR, 8'h10, 8'hA5}, '{KC, 8'h00, 8'h3C}, '{KC, 8'h00, 8'h7E},
    '{KW, 8'h41, 8'h19}, '{KW, 8'h40, 8'hC3}, '{KC, 8'h00, 8'h19},
    '{KR, 8'h40, 8'hC3}
  };

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hp();
    repeat (4) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1; hp(); sclM = 1; hp(); sdaM = 0; hp(); sclM = 0; hp();
  endtask

  task automatic busStop();
    sdaM = 0; hp(); sclM = 1; hp(); sdaM = 1; hp();
  endtask

  task automatic putByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; hp(); sclM = 1; hp(); sclM = 0; hp();
    end
    sdaM = 1; hp(); sclM = 1; hp(); ack = ~sdaLine; sclM = 0; hp();
  endtask

  task automatic getByte(input logic mAck, output logic [7:0] b);
    b = '0;
    sdaM = 1;
    for (int i = 0; i < 8; i++) begin
      sclM = 1; hp(); b = {b[6:0], sdaLine}; sclM = 0; hp();
    end
    sdaM = ~mAck; hp(); sclM = 1; hp(); sclM = 0; hp(); sdaM = 1; hp();
  endtask

  task automatic writeBytes(input string req, input logic [2:0] sel, input logic [7:0] addr,
                            input logic [7:0] d0, input logic [7:0] d1, input int n);
    logic ack;
    busStart();
    putByte({4'b1010, sel, 1'b0}, ack); chk({req, " select ack"}, {7'b0, ack}, 8'd1);
    putByte(addr, ack);                 chk({req, " address ack"}, {7'b0, ack}, 8'd1);
    putByte(d0, ack);                   chk({req, " data ack"}, {7'b0, ack}, 8'd1);
    if (n > 1) begin
      putByte(d1, ack);                 chk({req, " data ack"}, {7'b0, ack}, 8'd1);
    end
    busStop();
  endtask

  // random read opening: address phase, repeated start, read select
  task automatic openRead(input string req, input logic [2:0] sel, input logic useAddr,
                          input logic [7:0] addr);
    logic ack;
    busStart();
    if (useAddr) begin
      putByte({4'b1010, sel, 1'b0}, ack);
      putByte(addr, ack);
      busStart();
    end
    putByte({4'b1010, sel, 1'b1}, ack); chk({req, " read select ack"}, {7'b0, ack}, 8'd1);
  endtask

  task automatic readOne(input string req, input logic [2:0] sel, input logic useAddr,
                         input logic [7:0] addr, input logic [7:0] exp);
    logic [7:0] b;
    openRead(req, sel, useAddr, addr);
    getByte(1'b0, b);
    chk({req, " read data"}, b, exp);
    busStop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    logic [7:0] b;
    logic ack;
    logic seenDrive;
    repeat (5) @(negedge clk);
    rstN = 1;
    hp();
    // R10: released after reset, no drive on clocks without a start
    chk("R10 reset release", {6'b0, oeA, oeB}, 8'd0);
    seenDrive = 0;
    sclM = 0; hp(); sdaM = 0; hp();
    for (int i = 0; i < 9; i++) begin
      sclM = 1; hp(); seenDrive |= oeA; sclM = 0; hp(); seenDrive |= oeA;
    end
    sdaM = 1; hp(); sclM = 1; hp();
    chk("R10 no drive without start", {7'b0, seenDrive}, 8'd0);

    // vector table on 2 Kbit device: R3 writes, R7 current reads, R5 ordering
    for (int i = 0; i < NVEC; i++) begin
      case (VECS[i].kind)
        KW: writeBytes("R3", 3'b101, VECS[i].addr, VECS[i].data, 8'h00, 1);
        KR: readOne("R5", 3'b101, 1'b1, VECS[i].addr, VECS[i].data);
        default: readOne("R7", 3'b101, 1'b0, 8'h00, VECS[i].data);
      endcase
    end

    // R1: wrong chip select and wrong prefix are not acknowledged
    busStart();
    putByte({4'b1010, 3'b000, 1'b1}, ack);
    chk("R1 chip mismatch no ack", {7'b0, ack}, 8'd0);
    getByte(1'b0, b);
    chk("R1 off bus after mismatch", b, 8'hFF);
    busStop();
    busStart();
    putByte({4'b1011, 3'b101, 1'b1}, ack);
    chk("R1 prefix mismatch no ack", {7'b0, ack}, 8'd0);
    busStop();

    // R4: write wraps inside 8-byte page at 2 Kbit
    writeBytes("R4", 3'b101, 8'h0F, 8'h11, 8'h22, 2);
    readOne("R4 wrapped byte", 3'b101, 1'b1, 8'h08, 8'h22);
    readOne("R4 first byte", 3'b101, 1'b1, 8'h0F, 8'h11);

    // R5: read advance wraps from top of array
    writeBytes("R5", 3'b101, 8'hFF, 8'h5A, 8'h00, 1);
    writeBytes("R5", 3'b101, 8'h00, 8'h6B, 8'h00, 1);
    readOne("R5 top byte", 3'b101, 1'b1, 8'hFF, 8'h5A);
    readOne("R5 wrap to zero", 3'b101, 1'b0, 8'h00, 8'h6B);

    // R6: master ack continues, nack ends
    writeBytes("R6", 3'b101, 8'h20, 8'h01, 8'h02, 2);
    writeBytes("R6", 3'b101, 8'h22, 8'h03, 8'h00, 1);
    openRead("R6", 3'b101, 1'b1, 8'h20);
    getByte(1'b1, b); chk("R6 first byte", b, 8'h01);
    getByte(1'b0, b); chk("R6 continued byte", b, 8'h02);
    getByte(1'b0, b); chk("R6 released after nack", b, 8'hFF);
    busStop();
    readOne("R6 pointer after burst", 3'b101, 1'b0, 8'h00, 8'h03);

    // R8: start in mid address keeps pointer
    writeBytes("R8", 3'b101, 8'h31, 8'h88, 8'h00, 1);
    writeBytes("R8", 3'b101, 8'h30, 8'h77, 8'h00, 1);
    busStart();
    putByte({4'b1010, 3'b101, 1'b0}, ack);
    for (int i = 0; i < 4; i++) begin
      sdaM = 0; hp(); sclM = 1; hp(); sclM = 0; hp();
    end
    readOne("R8 pointer kept over restart", 3'b101, 1'b0, 8'h00, 8'h88);

    // 16 Kbit device: R2 page bits, R4 16-byte wrap, R5 full range
    busSel = 1; hp();
    writeBytes("R2", 3'b101, 8'h20, 8'hD4, 8'h00, 1);
    writeBytes("R2", 3'b000, 8'h20, 8'h4D, 8'h00, 1);
    readOne("R2 page five", 3'b101, 1'b1, 8'h20, 8'hD4);
    readOne("R2 page zero", 3'b000, 1'b1, 8'h20, 8'h4D);
    writeBytes("R4", 3'b101, 8'h2F, 8'hE1, 8'hE2, 2);
    readOne("R4 page wrap 16K", 3'b101, 1'b1, 8'h20, 8'hE2);
    readOne("R4 page end 16K", 3'b101, 1'b1, 8'h2F, 8'hE1);
    writeBytes("R5", 3'b111, 8'hFF, 8'h99, 8'h00, 1);
    writeBytes("R5", 3'b000, 8'h00, 8'h55, 8'h00, 1);
    openRead("R5", 3'b111, 1'b1, 8'hFF);
    getByte(1'b1, b); chk("R5 top of 16K", b, 8'h99);
    getByte(1'b0, b); chk("R5 wrap of 16K", b, 8'h55);
    busStop();
    busSel = 0; hp();

    finishRun();
  end

endmodule